// File: doc/BRIEF.md
# Multi-Crate Test Start Synchronizer

Three crates share one high-voltage supply, and only one of them, the controller, may drive it. A self-test that ramps that supply must therefore begin on all crates at the same moment, and only once every crate is prepared for it. This block coordinates that start through open-drain lines that run between the crates. Each follower crate owns a release line. It holds the line low until it has been asked to take part in a test and is locally ready, and then it lets the line float high. The controller owns the begin line.

The same module serves both roles, and a parameter selects which one. An open-drain driver appears at the ports as a pull-enable output: when the output is 1, the line is driven low. Line readings come back in as the wired-AND of every driver on that line. In the controller role, a test request moves the block into a wait state. Once every release line has read high for long enough, the block pulls the begin line low for a fixed window and then reports that the test is running. If the releases do not all arrive in time, the block gives up and raises an error flag. In the follower role, the block watches for the falling edge of the begin line, starts its own test, and pulls its release line low again.

Top module: `test_start_sync`

## Requirements
- R1: During and after reset, neither role pulls the begin line, `test_go`, `running` and `sync_err` are 0, and a follower pulls its release line low (`rel_pull`=1).
- R2: A follower sets `rel_pull`=0 only while it is armed and `local_ready` is 1. It becomes armed on a `test_req` cycle. In every other case it keeps `rel_pull`=1.
- R3: Every line input passes through SYNC_STAGES flops. The controller accepts a release line only after the synchronized line has read high for STABLE_CYC consecutive cycles. A high pulse that is shorter than this does not start a test.
- R4: The controller leaves idle only on a `test_req` cycle. A `test_req` that arrives while it is waiting, in its begin window or running has no effect. While it is idle, released lines alone start nothing.
- R5: Suppose the last release line is sampled high at rising edge k, the controller is waiting, and every other line has already been accepted. Then `beg_pull` rises at edge k+SYNC_STAGES+STABLE_CYC and stays at 1 for exactly BEGIN_CYC cycles. `test_go` is 1 during the first of those cycles only.
- R6: If the controller spends TIMEOUT_CYC cycles waiting without accepting every line, it returns to idle with `sync_err`=1. The next `test_req` clears `sync_err`.
- R7: In the controller, `running` becomes 1 right after the begin window ends and stays 1 until a `test_done` cycle.
- R8: A follower treats a falling edge of the synchronized begin line as the start signal. It pulses `test_go` for one cycle, sets `running` (which `test_done` clears), and disarms, so that `rel_pull` returns to 1 until the next `test_req`. This happens even when the follower is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_req | input | 1 | Test request: starts the wait in the controller, arms a follower |
| test_done | input | 1 | Local test finished, clears `running` |
| local_ready | input | 1 | Follower is prepared to release its line |
| rel_line | input | N_PEERS | Wired-AND readings of the release lines |
| beg_line | input | 1 | Wired-AND reading of the begin line |
| rel_pull | output | 1 | Pull own release line low (follower) |
| beg_pull | output | 1 | Pull begin line low (controller) |
| test_go | output | 1 | One-cycle start pulse |
| running | output | 1 | Test in progress |
| sync_err | output | 1 | Controller timed out waiting for releases |

## Verification
The bench connects a controller and a follower through modelled wired-AND lines and adds a second peer that it drives itself. It goes after the following cases. A release that arrives after the request is measured for exact latency, so a design with an extra or a missing synchronizer or stability stage starts a cycle off. A short release glitch must not start a test, and a design without the stability count would start one. A wait with no releases must time out with the error flag set, which a design with a broken timer would either miss or report early. Requests that arrive while the test runs must be ignored, so a design that restarted the handshake would drop `running`. On the follower side, the bench checks that the line is pulled low again after the begin edge and that a begin edge arriving while the follower is not armed still starts the follower.

// File: rtl/test_start_sync.sv
module test_start_sync #(
  parameter bit IS_CTRL     = 1'b1,
  parameter int N_PEERS     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4,
  parameter int BEGIN_CYC   = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_req,
  input  logic               test_done,
  input  logic               local_ready,
  input  logic [N_PEERS-1:0] rel_line,
  input  logic               beg_line,
  output logic               rel_pull,
  output logic               beg_pull,
  output logic               test_go,
  output logic               running,
  output logic               sync_err
);
  localparam int CMAX = (TIMEOUT_CYC > BEGIN_CYC) ? TIMEOUT_CYC : BEGIN_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = $clog2(STABLE_CYC + 1);
  localparam logic [N_PEERS:0] SYNC_RST = {1'b1, {N_PEERS{1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BEGIN, S_RUN} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             err;
  logic [N_PEERS:0] sreg [SYNC_STAGES];
  logic [N_PEERS:0] syn;
  logic [N_PEERS-1:0] accepted;
  logic             all_ok;
  logic             beg_d, beg_fall, armed, f_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sreg[i] <= SYNC_RST;
    end else begin
      sreg[0] <= {beg_line, rel_line};
      for (int i = 1; i < SYNC_STAGES; i++) sreg[i] <= sreg[i-1];
    end
  end

  assign syn = sreg[SYNC_STAGES-1];

  for (genvar p = 0; p < N_PEERS; p++) begin : g_stab
    logic [SW-1:0] stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          stab <= '0;
      else if (!syn[p])                    stab <= '0;
      else if (stab != SW'(STABLE_CYC))    stab <= stab + 1'b1;
    end
    assign accepted[p] = (stab == SW'(STABLE_CYC));
  end

  assign all_ok = &accepted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (test_req) begin
          st  <= S_WAIT;
          cnt <= '0;
          err <= 1'b0;
        end
        S_WAIT: if (all_ok) begin
          st  <= S_BEGIN;
          cnt <= '0;
        end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
          err <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_BEGIN: if (cnt == CW'(BEGIN_CYC - 1)) begin
          st  <= S_RUN;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (test_done) st <= S_IDLE;
      endcase
    end
  end

  assign beg_fall = beg_d & ~syn[N_PEERS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beg_d <= 1'b1;
      armed <= 1'b0;
      f_run <= 1'b0;
    end else begin
      beg_d <= syn[N_PEERS];
      if (beg_fall)      armed <= 1'b0;
      else if (test_req) armed <= 1'b1;
      if (beg_fall)       f_run <= 1'b1;
      else if (test_done) f_run <= 1'b0;
    end
  end

  assign rel_pull = IS_CTRL ? 1'b0 : !(armed && local_ready);
  assign beg_pull = IS_CTRL && (st == S_BEGIN);
  assign test_go  = IS_CTRL ? (st == S_BEGIN && cnt == '0) : beg_fall;
  assign running  = IS_CTRL ? (st == S_RUN) : f_run;
  assign sync_err = IS_CTRL && err;
endmodule

// File: rtl/test_start_sync_chk.sv
module test_start_sync_chk #(
  parameter bit IS_CTRL     = 1'b1,
  parameter int N_PEERS     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4,
  parameter int BEGIN_CYC   = 8,
  parameter int TIMEOUT_CYC = 4096
) (
  input logic               clk,
  input logic               rst_n,
  input logic               test_req,
  input logic               test_done,
  input logic               local_ready,
  input logic [N_PEERS-1:0] rel_line,
  input logic               beg_line,
  input logic               rel_pull,
  input logic               beg_pull,
  input logic               test_go,
  input logic               running,
  input logic               sync_err
);
  int unsigned blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        blen <= 0;
    else if (beg_pull) blen <= blen + 1;
    else               blen <= 0;
  end

  p_begin_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beg_pull |-> blen < BEGIN_CYC);

  p_begin_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beg_pull) |-> blen == BEGIN_CYC);

  p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    test_go |=> !test_go);

  p_begin_needs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beg_pull) |-> &$past(rel_line, SYNC_STAGES));

  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> !running && !beg_pull);

  p_run_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running && test_done && !test_go |=> !running);

  p_run_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    IS_CTRL && running && !test_done |=> running);

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_CTRL && test_go && !test_req |=> rel_pull);
endmodule

bind test_start_sync test_start_sync_chk #(
  .IS_CTRL(IS_CTRL), .N_PEERS(N_PEERS), .SYNC_STAGES(SYNC_STAGES),
  .STABLE_CYC(STABLE_CYC), .BEGIN_CYC(BEGIN_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (.*);

// File: tb/test_start_sync_tb.sv
`timescale 1ns/100ps
module test_start_sync_tb;
  localparam int SY = 2, ST = 3, BG = 4, TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_req = 0, c_done = 0, f_req = 0, f_done = 0, f_ready = 0;
  logic peer_pull = 1, tb_beg_pull = 0;
  logic c_rel_pull, c_beg_pull, c_go, c_run, c_err;
  logic f_rel_pull, f_beg_pull, f_go, f_run, f_err;
  logic ln_r0, ln_r1, ln_b;

  always #2.5 clk = ~clk;

  assign ln_r0 = ~f_rel_pull & ~c_rel_pull;
  assign ln_r1 = ~peer_pull;
  assign ln_b  = ~(c_beg_pull | f_beg_pull | tb_beg_pull);

  test_start_sync #(.IS_CTRL(1'b1), .N_PEERS(2), .SYNC_STAGES(SY), .STABLE_CYC(ST),
                    .BEGIN_CYC(BG), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_req(c_req), .test_done(c_done), .local_ready(1'b0),
    .rel_line({ln_r1, ln_r0}), .beg_line(ln_b), .rel_pull(c_rel_pull), .beg_pull(c_beg_pull),
    .test_go(c_go), .running(c_run), .sync_err(c_err));

  test_start_sync #(.IS_CTRL(1'b0), .N_PEERS(2), .SYNC_STAGES(SY), .STABLE_CYC(ST),
                    .BEGIN_CYC(BG), .TIMEOUT_CYC(TO)) u_fol (
    .clk(clk), .rst_n(rst_n), .test_req(f_req), .test_done(f_done), .local_ready(f_ready),
    .rel_line({ln_r1, ln_r0}), .beg_line(ln_b), .rel_pull(f_rel_pull), .beg_pull(f_beg_pull),
    .test_go(f_go), .running(f_run), .sync_err(f_err));

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int cst = 0, ccnt = 0, stab0 = 0, stab1 = 0;
  bit cerr = 0, farmed = 0, frun = 0, fbprev = 1;
  bit q0[$], q1[$], qb[$];
  bit s_rst, s_creq, s_cdone, s_freq, s_fdone, s_r0, s_r1, s_b;
  bit seen_beg = 0;

  initial begin
    for (int i = 0; i < SY; i++) begin q0.push_back(0); q1.push_back(0); qb.push_back(1); end
  end

  always @(negedge clk) begin
    #1;
    chk("R1/R5 ctrl beg_pull", c_beg_pull, cst == 2);
    chk("R5 ctrl test_go", c_go, cst == 2 && ccnt == 0);
    chk("R7 ctrl running", c_run, cst == 3);
    chk("R6 ctrl sync_err", c_err, cerr);
    chk("R1 ctrl rel_pull", c_rel_pull, 1'b0);
    chk("R2 fol rel_pull", f_rel_pull, !(farmed && f_ready));
    chk("R8 fol test_go", f_go, fbprev && !qb[0]);
    chk("R8 fol running", f_run, frun);
    chk("R1 fol beg_pull", f_beg_pull, 1'b0);
    chk("R1 fol sync_err", f_err, 1'b0);
    if (c_beg_pull) seen_beg = 1;
    s_rst = rst_n; s_creq = c_req; s_cdone = c_done; s_freq = f_req; s_fdone = f_done;
    s_r0 = ln_r0; s_r1 = ln_r1; s_b = ln_b;
  end

  always @(posedge clk) begin
    if (!s_rst) begin
      cst = 0; ccnt = 0; cerr = 0; stab0 = 0; stab1 = 0;
      farmed = 0; frun = 0; fbprev = 1;
      for (int i = 0; i < SY; i++) begin q0[i] = 0; q1[i] = 0; qb[i] = 1; end
    end else begin
      bit ok, fall;
      ok = (stab0 == ST) && (stab1 == ST);
      fall = fbprev && !qb[0];
      case (cst)
        0: if (s_creq) begin cst = 1; ccnt = 0; cerr = 0; end
        1: if (ok) begin cst = 2; ccnt = 0; end
           else if (ccnt == TO - 1) begin cst = 0; ccnt = 0; cerr = 1; end
           else ccnt++;
        2: if (ccnt == BG - 1) begin cst = 3; ccnt = 0; end else ccnt++;
        default: if (s_cdone) cst = 0;
      endcase
      stab0 = q0[0] ? ((stab0 < ST) ? stab0 + 1 : ST) : 0;
      stab1 = q1[0] ? ((stab1 < ST) ? stab1 + 1 : ST) : 0;
      if (fall) farmed = 0; else if (s_freq) farmed = 1;
      if (fall) frun = 1; else if (s_fdone) frun = 0;
      fbprev = qb[0];
      void'(q0.pop_front()); q0.push_back(s_r0);
      void'(q1.pop_front()); q1.push_back(s_r1);
      void'(qb.pop_front()); qb.push_back(s_b);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_creq; @(negedge clk); c_req = 1; @(negedge clk); c_req = 0; endtask
  task automatic pulse_freq; @(negedge clk); f_req = 1; @(negedge clk); f_req = 0; endtask

  task automatic finish_run;
    @(negedge clk); c_done = 1; f_done = 1;
    @(negedge clk); c_done = 0; f_done = 0;
    cyc(2);
    chk("R7 run cleared by done", c_run, 1'b0);
  endtask

  initial begin
    int n;
    cyc(4);
    chk("R1 reset rel_pull", f_rel_pull, 1'b1);
    chk("R1 reset beg_pull", c_beg_pull, 1'b0);
    rst_n = 1;
    cyc(2);
    chk("R1 after reset go", c_go | f_go, 1'b0);

    // R2: follower held low until armed and ready
    f_ready = 1; cyc(3);
    chk("R2 unarmed holds line", f_rel_pull, 1'b1);
    f_ready = 0; pulse_freq(); cyc(1);
    chk("R2 armed but not ready", f_rel_pull, 1'b1);
    f_ready = 1; cyc(1);
    chk("R2 armed and ready releases", f_rel_pull, 1'b0);

    // R4: released lines without request start nothing
    peer_pull = 0; seen_beg = 0; cyc(20);
    chk("R4 no start without req", seen_beg, 1'b0);

    // R5: exact latency from last release
    peer_pull = 1; cyc(6);
    pulse_creq(); cyc(3);
    peer_pull = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!c_beg_pull && n < 50);
    chk("R5 begin latency", n == SY + ST + 1, 1'b1);
    chk("R5 go with begin", c_go, 1'b1);
    n = 0;
    do begin @(negedge clk); n++; end while (!f_go && n < 20);
    chk("R8 follower sees begin", f_go, 1'b1);
    cyc(1);
    chk("R8 follower pulls line again", f_rel_pull, 1'b1);
    chk("R8 follower running", f_run, 1'b1);
    cyc(BG);
    chk("R7 ctrl running after window", c_run, 1'b1);
    pulse_creq(); cyc(3);
    chk("R4 req ignored while running", c_run, 1'b1);
    finish_run();

    // R6: timeout (follower not armed)
    pulse_creq(); cyc(TO + 3);
    chk("R6 timeout error", c_err, 1'b1);
    chk("R6 back to idle", c_beg_pull, 1'b0);
    pulse_creq();
    chk("R6 error cleared by req", c_err, 1'b0);

    // R3: short glitch does not start
    pulse_freq();
    peer_pull = 1; cyc(6);
    seen_beg = 0;
    peer_pull = 0; cyc(ST - 1); peer_pull = 1; cyc(10);
    chk("R3 glitch rejected", seen_beg, 1'b0);
    peer_pull = 0; cyc(12);
    chk("R3 steady release starts", seen_beg, 1'b1);
    cyc(BG + 4);
    finish_run();

    // R8: stray begin edge starts an unarmed follower
    @(negedge clk); tb_beg_pull = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!f_go && n < 20);
    chk("R8 unarmed follower go", f_go, 1'b1);
    tb_beg_pull = 0;
    cyc(4);
    f_done = 1; cyc(1); f_done = 0; cyc(2);
    chk("R8 follower done clears run", f_run, 1'b0);

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule